// File: doc/BRIEF.md
# Flash ISP Command Controller

This block lets firmware program, erase and read back an on-chip flash region through a few bus-mapped registers. Software loads an address, a data word and a command code, then writes a trigger bit. The controller first checks the request. If the request is valid, it runs the flash operation for a fixed number of cycles. During that window it pulls the bus ready line low, so the CPU bus master waits while the rest of the chip keeps running. If the request is invalid, nothing starts and a sticky fail flag is raised instead.

The control register holds the enable bit, the boot-source bit and the fail flag. It only accepts writes after software writes a three-byte key sequence to the key register. A power-on reset takes the boot source from a configuration input. A software reset takes it from the boot bit in the control register, so firmware can restart into the loader region.

The flash itself is a behavioural word memory of `DEPTH` 32-bit words. Erase works on aligned pages of `PAGE_WORDS` words.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After `rst`, `bus_ready` is 1, CTRL (index 0) and KEY (index 5) read as 0, and `boot_ldr` equals `cfg_boot_ldr`.
- R2: Unlock sequence and locked writes.
  - CTRL becomes writable only after three back-to-back KEY writes of 0x59, 0x16 and 0x88 (low byte).
  - Any other value restarts the sequence.
  - While locked, a CTRL write changes nothing.
  - KEY bit 0 reads 1 when unlocked.
- R3: Any KEY write while unlocked relocks CTRL.
- R4: A valid trigger (TRIG index 4, bit 0 = 1) holds `bus_ready` low for exactly PROG_CYC (20) cycles for command 0x21 (program), ERASE_CYC (200) cycles for 0x22 (erase) and READ_CYC (4) cycles for 0x00 (read).
- R5: Trigger rejection.
  - A trigger is rejected when CTRL bit 0 (enable) is 0, when `isp_clk_en` is 0, when ADDR is not word aligned, when ADDR is at or above DEPTH*4, or when CMD is not one of 0x00, 0x21, 0x22.
  - On rejection there is no stall, CTRL bit 6 (fail) is set and the flash is unchanged.
- R6: The fail flag stays set until an unlocked CTRL write with bit 6 = 1. An unlocked write with bit 6 = 0 leaves it set.
- R7: A valid trigger runs normally while the fail flag is set.
- R8: Program stores DATA (index 2) at the word at byte address ADDR (index 1). A read command makes DATA read back that word.
- R9: Erase sets every word of the aligned PAGE_WORDS-word page that contains ADDR to 0xFFFFFFFF.
- R10: TRIG reads 0 once an operation has finished (the trigger bit clears itself).
- R11: A `sw_rst` pulse loads `boot_ldr` from CTRL bit 1, and `rst` loads it from `cfg_boot_ldr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sw_rst | input | 1 | Software reset pulse; samples the boot bit |
| isp_clk_en | input | 1 | Programming clock enable from clock control |
| cfg_boot_ldr | input | 1 | Configuration boot source used at power-on |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the access |
| bus_ready | output | 1 | Low while an operation runs; accesses are ignored then |
| boot_ldr | output | 1 | 1 = boot from loader region |

## Verification
A register write takes effect at the clock edge that samples it. Read data is registered, so it is valid one cycle after the read request, and the bench samples it on the following falling edge.

After a trigger edge, `bus_ready` is first low at the next falling edge. The bench counts falling edges with `bus_ready` low until it returns high, and that count must equal the cycle count for the command exactly. A rejected trigger must give a count of zero.

The boot output is registered, so it is checked one falling edge after the `sw_rst` or `rst` edge.

// File: rtl/flash_isp_pkg.sv
package flash_isp_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RG_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RG_ADDR = 3'd1;
  localparam logic [REG_AW-1:0] RG_DATA = 3'd2;
  localparam logic [REG_AW-1:0] RG_CMD  = 3'd3;
  localparam logic [REG_AW-1:0] RG_TRIG = 3'd4;
  localparam logic [REG_AW-1:0] RG_KEY  = 3'd5;

  localparam logic [7:0] OP_READ  = 8'h00;
  localparam logic [7:0] OP_PROG  = 8'h21;
  localparam logic [7:0] OP_ERASE = 8'h22;

  localparam logic [7:0] UNLOCK_A = 8'h59;
  localparam logic [7:0] UNLOCK_B = 8'h16;
  localparam logic [7:0] UNLOCK_C = 8'h88;

  localparam int BIT_EN   = 0;
  localparam int BIT_BOOT = 1;
  localparam int BIT_FAIL = 6;

  typedef enum logic [1:0] {KS_IDLE, KS_GOT_A, KS_GOT_B, KS_OPEN} key_state_e;

  function automatic logic op_known(input logic [7:0] c);
    return (c == OP_READ) || (c == OP_PROG) || (c == OP_ERASE);
  endfunction
endpackage

// File: rtl/isp_key_gate.sv
module isp_key_gate
  import flash_isp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  output logic       unlocked
);
  key_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KS_IDLE;
    end else if (key_wr) begin
      case (st_q)
        KS_IDLE:  st_q <= (key_val == UNLOCK_A) ? KS_GOT_A : KS_IDLE;
        KS_GOT_A: st_q <= (key_val == UNLOCK_B) ? KS_GOT_B : KS_IDLE;
        KS_GOT_B: st_q <= (key_val == UNLOCK_C) ? KS_OPEN  : KS_IDLE;
        default:  st_q <= KS_IDLE;
      endcase
    end
  end

  assign unlocked = (st_q == KS_OPEN);

  assert_relock_R3: assert property (@(posedge clk) disable iff (rst)
    (unlocked && key_wr) |=> !unlocked);

  assert_open_needs_last_key_R2: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && !(key_wr && key_val == UNLOCK_C)) |=> !unlocked);
endmodule

// File: rtl/isp_flash_mem.sv
module isp_flash_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/isp_op_seq.sv
module isp_op_seq
  import flash_isp_pkg::*;
#(
  parameter int PROG_CYC   = 20,
  parameter int ERASE_CYC  = 200,
  parameter int READ_CYC   = 4,
  parameter int PAGE_WORDS = 4,
  parameter int AW         = 6,
  parameter int DW         = 32,
  localparam int MAXC_A    = (PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC,
  localparam int MAXC      = (ERASE_CYC > MAXC_A) ? ERASE_CYC : MAXC_A,
  localparam int CNT_W     = $clog2(MAXC + 1),
  localparam int PB        = $clog2(PAGE_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    cmd,
  input  logic [AW-1:0] word_addr,
  input  logic [DW-1:0] data_in,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] mem_raddr,
  output logic          rd_take
);
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       op_q;
  logic [AW-1:0]    base_q;
  logic [DW-1:0]    data_q;
  int               len;

  always_comb begin
    case (cmd)
      OP_PROG:  len = PROG_CYC;
      OP_ERASE: len = ERASE_CYC;
      default:  len = READ_CYC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_READ;
      base_q <= '0;
      data_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt_q  <= CNT_W'(len - 1);
      op_q   <= cmd;
      base_q <= word_addr;
      data_q <= data_in;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  logic erase_slot;
  assign erase_slot = (op_q == OP_ERASE) && (cnt_q < CNT_W'(PAGE_WORDS));

  assign mem_we    = busy && (((op_q == OP_PROG) && (cnt_q == '0)) || erase_slot);
  assign mem_waddr = (op_q == OP_ERASE) ? {base_q[AW-1:PB], cnt_q[PB-1:0]} : base_q;
  assign mem_wdata = (op_q == OP_ERASE) ? {DW{1'b1}} : data_q;
  assign mem_raddr = base_q;
  assign rd_take   = busy && (op_q == OP_READ) && (cnt_q == '0);

  assert_start_stalls_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - 1'b1));

  assert_idle_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !mem_we);
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import flash_isp_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int PAGE_WORDS = 4,
  parameter int PROG_CYC   = 20,
  parameter int ERASE_CYC  = 200,
  parameter int READ_CYC   = 4,
  localparam int DW        = 32,
  localparam int MAW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              isp_clk_en,
  input  logic              cfg_boot_ldr,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ready,
  output logic              boot_ldr
);
  logic          busy, unlocked;
  logic          en_q, boot_q, fail_q;
  logic [DW-1:0] addr_q, data_q, rd_q, mem_rdata;
  logic [7:0]    cmd_q;
  logic          mem_we, rd_take;
  logic [MAW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata;

  logic acc, wr_acc, ctrl_wr, key_wr, trig_wr, req_bad, start;

  assign bus_ready = !busy;
  assign acc     = bus_sel && !busy;
  assign wr_acc  = acc && bus_wr;
  assign ctrl_wr = wr_acc && (bus_addr == RG_CTRL);
  assign key_wr  = wr_acc && (bus_addr == RG_KEY);
  assign trig_wr = wr_acc && (bus_addr == RG_TRIG) && bus_wdata[0];

  assign req_bad = !en_q || !isp_clk_en || (addr_q[1:0] != 2'b00) ||
                   ((addr_q >> 2) >= DW'(DEPTH)) || !op_known(cmd_q);
  assign start   = trig_wr && !req_bad;

  isp_key_gate u_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (key_wr),
    .key_val  (bus_wdata[7:0]),
    .unlocked (unlocked)
  );

  isp_op_seq #(
    .PROG_CYC   (PROG_CYC),
    .ERASE_CYC  (ERASE_CYC),
    .READ_CYC   (READ_CYC),
    .PAGE_WORDS (PAGE_WORDS),
    .AW         (MAW),
    .DW         (DW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd       (cmd_q),
    .word_addr (addr_q[MAW+1:2]),
    .data_in   (data_q),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .rd_take   (rd_take)
  );

  isp_flash_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      boot_q <= 1'b0;
      fail_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      cmd_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (ctrl_wr && unlocked) begin
        en_q   <= bus_wdata[BIT_EN];
        boot_q <= bus_wdata[BIT_BOOT];
        if (bus_wdata[BIT_FAIL]) fail_q <= 1'b0;
      end
      if (trig_wr && req_bad) fail_q <= 1'b1;
      if (wr_acc && bus_addr == RG_ADDR) addr_q <= bus_wdata;
      if (wr_acc && bus_addr == RG_DATA) data_q <= bus_wdata;
      if (wr_acc && bus_addr == RG_CMD)  cmd_q  <= bus_wdata[7:0];
      if (rd_take) rd_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         boot_ldr <= cfg_boot_ldr;
    else if (sw_rst) boot_ldr <= boot_q;
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      RG_CTRL: begin
        rd_mux[BIT_EN]   = en_q;
        rd_mux[BIT_BOOT] = boot_q;
        rd_mux[BIT_FAIL] = fail_q;
      end
      RG_ADDR: rd_mux = addr_q;
      RG_DATA: rd_mux = rd_q;
      RG_CMD:  rd_mux = {24'd0, cmd_q};
      RG_TRIG: rd_mux[0] = busy;
      RG_KEY:  rd_mux[0] = unlocked;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                 bus_rdata <= '0;
    else if (acc && !bus_wr) bus_rdata <= rd_mux;
  end

  assert_locked_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !unlocked && !trig_wr) |=> ($stable(en_q) && $stable(boot_q)));

  assert_reject_no_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (trig_wr && req_bad) |=> (bus_ready && fail_q));

  assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !(ctrl_wr && unlocked && bus_wdata[BIT_FAIL])) |=> fail_q);

  assert_busy_ignores_bus_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_sel) |=> ($stable(addr_q) && $stable(cmd_q)));
endmodule

// File: tb/tb_flash_isp_ctrl.sv
module tb_flash_isp_ctrl;
  localparam int DEPTH = 64;
  localparam int PW    = 4;

  logic        clk = 1'b0;
  logic        rst, sw_rst, isp_clk_en, cfg_boot_ldr;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready, boot_ldr;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] model [DEPTH];
  bit          known [DEPTH];

  flash_isp_ctrl dut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .isp_clk_en(isp_clk_en),
    .cfg_boot_ldr(cfg_boot_ldr), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .boot_ldr(boot_ldr)
  );

  always #10 clk = ~clk;

  function automatic int stall_of(input logic [7:0] c);
    if (c == 8'h21) return 20;
    if (c == 8'h22) return 200;
    return 4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(3'd5, 32'h59); wr(3'd5, 32'h16); wr(3'd5, 32'h88);
  endtask

  // trigger and return the number of stalled cycles
  task automatic op(input logic [7:0] c, input logic [31:0] a, input logic [31:0] d,
                    output int stall);
    wr(3'd1, a); wr(3'd2, d); wr(3'd3, {24'd0, c});
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd4; bus_wdata = 32'h1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    stall = 0;
    while (!bus_ready) begin stall++; @(negedge clk); end
  endtask

  task automatic read_word(input int w, input string req);
    int s; logic [31:0] v;
    op(8'h00, 32'(w * 4), 32'h0, s);
    chk({req, " read stall R4"}, 32'(s), 32'(stall_of(8'h00)));
    rd(3'd2, v);
    chk(req, v, model[w]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int s; logic [31:0] v; int w, pg;
    void'($urandom(32'd20240611));
    rst = 1; sw_rst = 0; isp_clk_en = 1; cfg_boot_ldr = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    chk("R1 ready", {31'd0, bus_ready}, 32'd1);
    chk("R1 boot", {31'd0, boot_ldr}, 32'd0);
    rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
    rd(3'd5, v); chk("R1 key", v, 32'd0);

    // R2: locked write ignored, wrong key restarts
    wr(3'd0, 32'h3); rd(3'd0, v); chk("R2 locked ctrl", v, 32'd0);
    wr(3'd5, 32'h59); wr(3'd5, 32'h16); wr(3'd5, 32'h77); wr(3'd5, 32'h88);
    rd(3'd5, v); chk("R2 bad key stays locked", v, 32'd0);
    unlock(); rd(3'd5, v); chk("R2 unlocked", v, 32'd1);
    wr(3'd0, 32'h1); rd(3'd0, v); chk("R2 ctrl written", v, 32'h1);

    // R3: relock
    wr(3'd5, 32'h59); rd(3'd5, v); chk("R3 relock", v, 32'd0);
    wr(3'd0, 32'h0); rd(3'd0, v); chk("R3 ctrl kept after relock", v, 32'h1);

    // R8/R4 directed program + read at ends of region
    op(8'h21, 32'h0, 32'hA5A5_0001, s); chk("R4 prog stall", 32'(s), 32'd20);
    model[0] = 32'hA5A5_0001; known[0] = 1;
    op(8'h21, 32'((DEPTH - 1) * 4), 32'h1234_5678, s); chk("R4 prog stall top", 32'(s), 32'd20);
    model[DEPTH-1] = 32'h1234_5678; known[DEPTH-1] = 1;
    read_word(0, "R8 word 0");
    read_word(DEPTH - 1, "R8 top word");
    rd(3'd4, v); chk("R10 trig self-clear", v, 32'd0);

    // R5 rejections
    op(8'h21, 32'(DEPTH * 4), 32'h0, s); chk("R5 out of range no stall", 32'(s), 32'd0);
    rd(3'd0, v); chk("R5 fail set", v, 32'h41);
    op(8'h21, 32'h2, 32'h0, s); chk("R5 misaligned", 32'(s), 32'd0);
    op(8'h33, 32'h0, 32'h0, s); chk("R5 bad cmd", 32'(s), 32'd0);
    isp_clk_en = 0;
    op(8'h21, 32'h0, 32'hDEAD_BEEF, s); chk("R5 clock off", 32'(s), 32'd0);
    isp_clk_en = 1;
    unlock(); wr(3'd0, 32'h0); wr(3'd5, 32'h0);
    op(8'h21, 32'h0, 32'hDEAD_BEEF, s); chk("R5 disabled", 32'(s), 32'd0);
    unlock(); wr(3'd0, 32'h1); wr(3'd5, 32'h0);

    // R7: fail still set, valid op runs; R5 memory unchanged
    rd(3'd0, v); chk("R6 fail still set", v, 32'h41);
    read_word(0, "R5 memory unchanged after reject");
    op(8'h21, 32'h4, 32'h0BAD_F00D, s); chk("R7 runs with fail set", 32'(s), 32'd20);
    model[1] = 32'h0BAD_F00D; known[1] = 1;

    // R6: clear
    unlock(); wr(3'd0, 32'h1); rd(3'd0, v); chk("R6 write 0 keeps fail", v, 32'h41);
    wr(3'd0, 32'h41); rd(3'd0, v); chk("R6 cleared", v, 32'h1);

    // random programs
    for (int i = 0; i < 30; i++) begin
      logic [31:0] d;
      w = int'($urandom % DEPTH); d = $urandom;
      op(8'h21, 32'(w * 4), d, s); chk("R4 random prog stall", 32'(s), 32'd20);
      model[w] = d; known[w] = 1;
    end

    // R9 erase a random page
    pg = int'($urandom % (DEPTH / PW));
    op(8'h22, 32'((pg * PW + 2) * 4), 32'h0, s); chk("R4 erase stall", 32'(s), 32'd200);
    for (int k = 0; k < PW; k++) begin model[pg*PW+k] = 32'hFFFF_FFFF; known[pg*PW+k] = 1; end
    for (int k = 0; k < PW; k++) read_word(pg * PW + k, "R9 erased word");

    for (int i = 0; i < DEPTH; i++) if (known[i]) read_word(i, "R8 random readback");

    // R11 boot source
    wr(3'd0, 32'h3);
    @(negedge clk) sw_rst = 1; @(negedge clk) sw_rst = 0;
    chk("R11 sw_rst loader", {31'd0, boot_ldr}, 32'd1);
    wr(3'd0, 32'h1);
    @(negedge clk) sw_rst = 1; @(negedge clk) sw_rst = 0;
    chk("R11 sw_rst main", {31'd0, boot_ldr}, 32'd0);
    cfg_boot_ldr = 1;
    @(negedge clk) rst = 1; @(negedge clk) rst = 0;
    chk("R11 por cfg", {31'd0, boot_ldr}, 32'd1);
    chk("R1 ready after reset", {31'd0, bus_ready}, 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule